// File: doc/BRIEF.md
# Stateful-Logic Ripple-Carry Adder Sequencer

This block adds two unsigned operands that already sit in a bit-addressable stateful cell array. It never touches the data itself. Instead it issues a stream of micro-operations to an external array engine, one at a time, over a valid/ready channel. Only two operations exist: a RESET, which clears a target cell, and an IMPLY, which performs `target <= !source | target`.

A two-input NAND is built as a RESET of the output cell followed by an IMPLY from each input cell into it. Each result bit comes from a nine-NAND full adder. The first three gates write into per-bit staging cells. Their outputs are then copied into fixed working cells, so that the remaining six gates use the same cells for every bit. A copy needs a zeroed auxiliary cell and is performed as two inversions. Scratch cells are cleared as soon as their value is dead.

After each bit, the sum is parked in its own storage cell and the carry is copied into the carry-in cell for the next bit. For the top bit, the carry goes to a dedicated overflow cell instead. A start pulse launches a run. At the end the block reports how many RESET and IMPLY operations it issued, and it either pulses done or, if the engine rejects an operation, pulses abort.

Top module: `imply_adder_ctrl`

## Requirements
- R1: While reset is held (active-low `rst_n`) and after its release, `busy`, `done`, `abort` and `op_valid` are 0, and both operation counters read 0.
- R2: The encoding is `op_code` 0 = RESET (target cleared, source ignored) and 1 = IMPLY (target becomes NOT source OR target). While `op_valid` is high and `op_ready` is low, `op_valid`, `op_code`, `op_src` and `op_tgt` stay unchanged.
- R3: The first operation after `start` is a RESET of the carry-in cell at address 3*NB+1, so that bit 0 sees a carry-in of 0.
- R4: After `done`, the cell at address 2*NB+i holds bit i of A+B for every i, and the cell at address 3*NB holds the carry out of the top bit. A is read from cells 0..NB-1 and B from cells NB..2*NB-1. This holds whatever the other cells contained beforehand.
- R5: The operand cells 0..2*NB-1 are never a target, so A and B are unchanged after a run.
- R6: `done` is high for exactly one cycle, in the cycle after the final accepted operation, and `busy` is low in that cycle.
- R7: When `done` is high, `cnt_reset` equals 31*NB+1 and `cnt_imply` equals 28*NB.
- R8: No IMPLY names the same cell as source and target, and every address is below 3*NB+18.
- R9: If `op_err` is high on an accepted operation, `abort` pulses in the next cycle and `busy` drops. No further operation is issued, `done` does not pulse, and that operation is excluded from the counters.
- R10: A `start` pulse during a run has no effect: the run completes with the R4 and R7 results.
- R11: Any pattern of `op_ready` stalls yields the same final cell contents and counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| op_valid | output | 1 | A micro-operation is presented |
| op_ready | input | 1 | Engine accepts the presented operation |
| op_code | output | 1 | 0 = RESET, 1 = IMPLY |
| op_src | output | clog2(3*NB+18) | Source cell address (IMPLY only) |
| op_tgt | output | clog2(3*NB+18) | Target cell address |
| op_err | input | 1 | Engine rejects the accepted operation |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| abort | output | 1 | One-cycle pulse after a rejected operation |
| cnt_reset | output | clog2(32*NB+2) | RESET operations issued in the last run |
| cnt_imply | output | clog2(32*NB+2) | IMPLY operations issued in the last run |

## Verification
The bench builds the block with NB = 8 and STAGE_SETS = 2. At NB = 8 the full 473-operation program runs, and the carry passes through all eight bit slots. Operands such as 255+255 and 128+128 therefore send the final carry into the overflow cell. With two staging sets, consecutive bits alternate between disjoint staging cells, which exercises the parity-dependent placement table. Because the bench's own cell model starts every run with random contents in the non-operand cells, a missing clear or a wrong copy shows up in the sums.

// File: rtl/imply_adder_pkg.sv
`timescale 1ns/1ps
package imply_adder_pkg;

   typedef enum logic {
      OP_RESET = 1'b0,
      OP_IMPLY = 1'b1
   } op_e;

   typedef enum logic [1:0] {
      MK_NAND = 2'd0,
      MK_MOVE = 2'd1,
      MK_CLR  = 2'd2
   } mkind_e;

   localparam int STEPS_PER_BIT = 26;

   // cell map, all derived from the operand width
   function automatic int cell_a(input int nb, input int i);
      return i;
   endfunction

   function automatic int cell_b(input int nb, input int i);
      return nb + i;
   endfunction

   function automatic int cell_sum(input int nb, input int i);
      return 2 * nb + i;
   endfunction

   function automatic int cell_ovf(input int nb);
      return 3 * nb;
   endfunction

   function automatic int cell_cin(input int nb);
      return 3 * nb + 1;
   endfunction

   // k = 1..7 selects one of the fixed internal working cells
   function automatic int cell_x(input int nb, input int k);
      return 3 * nb + 1 + k;
   endfunction

   function automatic int cell_s(input int nb);
      return 3 * nb + 9;
   endfunction

   function automatic int cell_co(input int nb);
      return 3 * nb + 10;
   endfunction

   function automatic int cell_aux(input int nb);
      return 3 * nb + 11;
   endfunction

   // k = 0..5 : two sets of three staging cells
   function automatic int cell_stage(input int nb, input int k);
      return 3 * nb + 12 + k;
   endfunction

   function automatic int cell_count(input int nb);
      return 3 * nb + 18;
   endfunction

endpackage

// File: rtl/imply_adder_rom.sv
`timescale 1ns/1ps
module imply_adder_rom
   import imply_adder_pkg::*;
#(
   parameter int NB         = 8,
   parameter int STAGE_SETS = 2,
   parameter int AW         = 6,
   parameter int BW         = 3,
   parameter int SW         = 5
) (
   input  logic [BW-1:0] bit_idx,
   input  logic [SW-1:0] step,
   output mkind_e        kind,
   output logic [AW-1:0] p,
   output logic [AW-1:0] q,
   output logic [AW-1:0] o
);

   logic          sel;
   logic [AW-1:0] a_c, b_c, sum_c, co_dst;
   logic [AW-1:0] s0, s1, s2;

   if (STAGE_SETS == 2) begin : g_alt
      assign sel = bit_idx[0];
   end else begin : g_one
      assign sel = 1'b0;
   end

   localparam logic [AW-1:0] X1  = AW'(cell_x(NB, 1));
   localparam logic [AW-1:0] X2  = AW'(cell_x(NB, 2));
   localparam logic [AW-1:0] X3  = AW'(cell_x(NB, 3));
   localparam logic [AW-1:0] X4  = AW'(cell_x(NB, 4));
   localparam logic [AW-1:0] X5  = AW'(cell_x(NB, 5));
   localparam logic [AW-1:0] X6  = AW'(cell_x(NB, 6));
   localparam logic [AW-1:0] X7  = AW'(cell_x(NB, 7));
   localparam logic [AW-1:0] SC  = AW'(cell_s(NB));
   localparam logic [AW-1:0] CO  = AW'(cell_co(NB));
   localparam logic [AW-1:0] CIN = AW'(cell_cin(NB));
   localparam logic [AW-1:0] OVF = AW'(cell_ovf(NB));
   localparam logic [AW-1:0] AUX = AW'(cell_aux(NB));

   always_comb begin
      a_c    = AW'(cell_a(NB, int'(bit_idx)));
      b_c    = AW'(cell_b(NB, int'(bit_idx)));
      sum_c  = AW'(cell_sum(NB, int'(bit_idx)));
      co_dst = (int'(bit_idx) == NB - 1) ? OVF : CIN;
      s0     = AW'(cell_stage(NB, 3 * int'(sel) + 0));
      s1     = AW'(cell_stage(NB, 3 * int'(sel) + 1));
      s2     = AW'(cell_stage(NB, 3 * int'(sel) + 2));
   end

   always_comb begin
      kind = MK_CLR;
      p    = '0;
      q    = '0;
      o    = AUX;
      case (int'(step))
         0:  begin kind = MK_NAND; p = a_c; q = b_c; o = s0; end
         1:  begin kind = MK_NAND; p = a_c; q = s0;  o = s1; end
         2:  begin kind = MK_NAND; p = b_c; q = s0;  o = s2; end
         3:  begin kind = MK_MOVE; p = s0;  o = X1; end
         4:  begin kind = MK_MOVE; p = s1;  o = X2; end
         5:  begin kind = MK_MOVE; p = s2;  o = X3; end
         6:  o = s0;
         7:  o = s1;
         8:  o = s2;
         9:  begin kind = MK_NAND; p = X2;  q = X3;  o = X4; end
         10: o = X2;
         11: o = X3;
         12: begin kind = MK_NAND; p = X4;  q = CIN; o = X5; end
         13: begin kind = MK_NAND; p = X4;  q = X5;  o = X6; end
         14: o = X4;
         15: begin kind = MK_NAND; p = CIN; q = X5;  o = X7; end
         16: begin kind = MK_NAND; p = X6;  q = X7;  o = SC; end
         17: o = X6;
         18: o = X7;
         19: begin kind = MK_NAND; p = X5;  q = X1;  o = CO; end
         20: o = X5;
         21: o = X1;
         22: begin kind = MK_MOVE; p = SC;  o = sum_c; end
         23: o = SC;
         24: begin kind = MK_MOVE; p = CO;  o = co_dst; end
         25: o = CO;
         default: o = AUX;
      endcase
   end

endmodule

// File: rtl/imply_adder_expand.sv
`timescale 1ns/1ps
module imply_adder_expand
   import imply_adder_pkg::*;
#(
   parameter int AW = 6
) (
   input  mkind_e        kind,
   input  logic [AW-1:0] p,
   input  logic [AW-1:0] q,
   input  logic [AW-1:0] o,
   input  logic [AW-1:0] aux,
   input  logic [1:0]    sub,
   output op_e           code,
   output logic [AW-1:0] src,
   output logic [AW-1:0] tgt,
   output logic          last_sub
);

   always_comb begin
      code     = OP_RESET;
      src      = '0;
      tgt      = o;
      last_sub = 1'b1;
      case (kind)
         MK_NAND: begin
            last_sub = (sub == 2'd2);
            case (sub)
               2'd0:    code = OP_RESET;
               2'd1:    begin code = OP_IMPLY; src = p; end
               default: begin code = OP_IMPLY; src = q; end
            endcase
         end
         MK_MOVE: begin
            last_sub = (sub == 2'd3);
            case (sub)
               2'd0:    tgt = aux;
               2'd1:    begin code = OP_IMPLY; src = p; tgt = aux; end
               2'd2:    tgt = o;
               default: begin code = OP_IMPLY; src = aux; end
            endcase
         end
         default: begin
            code     = OP_RESET;
            last_sub = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/imply_adder_ctrl.sv
`timescale 1ns/1ps
module imply_adder_ctrl
   import imply_adder_pkg::*;
#(
   parameter  int NB         = 8,
   parameter  int STAGE_SETS = 2,
   localparam int AW         = $clog2(3 * NB + 18),
   localparam int CW         = $clog2(32 * NB + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          op_valid,
   input  logic          op_ready,
   output logic          op_code,
   output logic [AW-1:0] op_src,
   output logic [AW-1:0] op_tgt,
   input  logic          op_err,
   output logic          busy,
   output logic          done,
   output logic          abort,
   output logic [CW-1:0] cnt_reset,
   output logic [CW-1:0] cnt_imply
);

   localparam int BW = (NB > 1) ? $clog2(NB) : 1;
   localparam int SW = $clog2(STEPS_PER_BIT);

   if (NB < 1) begin : g_bad_nb
      $error("imply_adder_ctrl: NB must be at least 1");
   end
   if (STAGE_SETS != 1 && STAGE_SETS != 2) begin : g_bad_sets
      $error("imply_adder_ctrl: STAGE_SETS must be 1 or 2");
   end

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRO  = 2'd1,
      ST_RUN  = 2'd2
   } state_e;

   state_e        state_q;
   logic [BW-1:0] bit_q;
   logic [SW-1:0] step_q;
   logic [1:0]    sub_q;
   logic          done_q, abort_q;
   logic [CW-1:0] rcnt_q, icnt_q;

   mkind_e        m_kind;
   logic [AW-1:0] m_p, m_q, m_o;
   op_e           x_code;
   logic [AW-1:0] x_src, x_tgt;
   logic          x_last;
   logic          hs, last_step, last_bit;

   imply_adder_rom #(
      .NB(NB), .STAGE_SETS(STAGE_SETS), .AW(AW), .BW(BW), .SW(SW)
   ) u_rom (
      .bit_idx (bit_q),
      .step    (step_q),
      .kind    (m_kind),
      .p       (m_p),
      .q       (m_q),
      .o       (m_o)
   );

   imply_adder_expand #(.AW(AW)) u_exp (
      .kind     (m_kind),
      .p        (m_p),
      .q        (m_q),
      .o        (m_o),
      .aux      (AW'(cell_aux(NB))),
      .sub      (sub_q),
      .code     (x_code),
      .src      (x_src),
      .tgt      (x_tgt),
      .last_sub (x_last)
   );

   always_comb begin
      op_valid = (state_q != ST_IDLE);
      if (state_q == ST_PRO) begin
         op_code = OP_RESET;
         op_src  = '0;
         op_tgt  = AW'(cell_cin(NB));
      end else begin
         op_code = x_code;
         op_src  = x_src;
         op_tgt  = x_tgt;
      end
   end

   assign hs        = op_valid && op_ready;
   assign last_step = (step_q == SW'(STEPS_PER_BIT - 1));
   assign last_bit  = (bit_q == BW'(NB - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         step_q  <= '0;
         sub_q   <= '0;
         done_q  <= 1'b0;
         abort_q <= 1'b0;
         rcnt_q  <= '0;
         icnt_q  <= '0;
      end else begin
         done_q  <= 1'b0;
         abort_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_PRO;
                  bit_q   <= '0;
                  step_q  <= '0;
                  sub_q   <= '0;
                  rcnt_q  <= '0;
                  icnt_q  <= '0;
               end
            end
            default: begin
               if (hs && op_err) begin
                  state_q <= ST_IDLE;
                  abort_q <= 1'b1;
               end else if (hs) begin
                  if (op_code == OP_IMPLY) icnt_q <= icnt_q + CW'(1);
                  else                     rcnt_q <= rcnt_q + CW'(1);
                  if (state_q == ST_PRO) begin
                     state_q <= ST_RUN;
                  end else if (!x_last) begin
                     sub_q <= sub_q + 2'd1;
                  end else begin
                     sub_q <= '0;
                     if (!last_step) begin
                        step_q <= step_q + SW'(1);
                     end else begin
                        step_q <= '0;
                        if (last_bit) begin
                           state_q <= ST_IDLE;
                           done_q  <= 1'b1;
                        end else begin
                           bit_q <= bit_q + BW'(1);
                        end
                     end
                  end
               end
            end
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign abort     = abort_q;
   assign cnt_reset = rcnt_q;
   assign cnt_imply = icnt_q;

endmodule

// File: rtl/imply_adder_chk.sv
`timescale 1ns/1ps
module imply_adder_chk
   import imply_adder_pkg::*;
#(
   parameter int NB = 8,
   parameter int AW = 6,
   parameter int CW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          op_valid,
   input logic          op_ready,
   input logic          op_code,
   input logic [AW-1:0] op_src,
   input logic [AW-1:0] op_tgt,
   input logic          op_err,
   input logic          busy,
   input logic          done,
   input logic          abort,
   input logic [CW-1:0] cnt_reset,
   input logic [CW-1:0] cnt_imply
);

   localparam int NCELL = cell_count(NB);

   // R2
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !op_ready |=> op_valid);

   // R2
   op_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !op_ready |=> $stable(op_code) && $stable(op_src) && $stable(op_tgt));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(op_valid && op_ready && !op_err) && !busy);

   // R8
   no_self_imply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_code == OP_IMPLY |-> op_src != op_tgt);

   // R8
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> (int'(op_src) < NCELL) && (int'(op_tgt) < NCELL));

   // R5
   operand_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> int'(op_tgt) >= 2 * NB);

   // R9
   abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> $past(op_valid && op_ready && op_err) && !op_valid && !done);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !op_valid);

endmodule

bind imply_adder_ctrl imply_adder_chk #(.NB(NB), .AW(AW), .CW(CW)) u_chk (.*);

// File: tb/tb_imply_adder_ctrl.sv
`timescale 1ns/1ps
module tb_imply_adder_ctrl;

   localparam int NB    = 8;
   localparam int NCELL = 3 * NB + 18;
   localparam int AW    = $clog2(NCELL);
   localparam int CW    = $clog2(32 * NB + 2);
   localparam int NV    = 10;

   // {a, b, expected a+b}
   localparam logic [24:0] VEC [NV] = '{
      {8'd0,   8'd0,   9'd0},
      {8'd255, 8'd1,   9'd256},
      {8'd255, 8'd255, 9'd510},
      {8'd170, 8'd85,  9'd255},
      {8'd128, 8'd128, 9'd256},
      {8'd1,   8'd1,   9'd2},
      {8'd100, 8'd27,  9'd127},
      {8'd15,  8'd240, 9'd255},
      {8'd200, 8'd99,  9'd299},
      {8'd0,   8'd255, 9'd255}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          op_valid, op_ready = 1'b0, op_code, op_err;
   logic [AW-1:0] op_src, op_tgt;
   logic          busy, done, abort;
   logic [CW-1:0] cnt_reset, cnt_imply;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   imply_adder_ctrl #(.NB(NB), .STAGE_SETS(2)) dut (
      .clk, .rst_n, .start, .op_valid, .op_ready, .op_code,
      .op_src, .op_tgt, .op_err, .busy, .done, .abort,
      .cnt_reset, .cnt_imply
   );

   // bench model of the stateful array engine
   logic          mem [NCELL];
   int            hs_num = 0;
   int            inject_at = -1;
   int            illegal = 0;
   logic          hs_flag = 1'b0;
   logic          first_code;
   logic [AW-1:0] first_tgt;
   logic          stall = 1'b0;

   assign op_err = op_valid && (hs_num == inject_at);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      hs_flag <= op_valid && op_ready && !op_err;
      if (rst_n && op_valid && op_ready) begin
         hs_num <= hs_num + 1;
         if (hs_num == 0) begin
            first_code <= op_code;
            first_tgt  <= op_tgt;
         end
         if ((op_code && op_src == op_tgt) || int'(op_src) >= NCELL || int'(op_tgt) >= NCELL)
            illegal <= illegal + 1;
         else if (!op_err) begin
            if (op_code) mem[op_tgt] <= !mem[op_src] | mem[op_tgt];
            else         mem[op_tgt] <= 1'b0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
         end
      end
   end

   task automatic run_add(input logic [7:0] a, input logic [7:0] b, input bit stl,
                          input bit mid_start, output bit got_done, output bit got_abort);
      got_done  = 1'b0;
      got_abort = 1'b0;
      @(negedge clk);
      for (int i = 0; i < NCELL; i++) mem[i] = 1'($urandom);
      for (int i = 0; i < NB; i++) begin
         mem[i]      = a[i];
         mem[NB + i] = b[i];
      end
      stall  = stl;
      hs_num = 0;
      illegal = 0;
      start  = 1'b1;
      op_ready = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 4000; k++) begin
         op_ready = stall ? 1'($urandom_range(1, 0)) : 1'b1;
         start = (mid_start && k == 40);
         @(negedge clk);
         if (done) begin
            got_done = 1'b1;
            // R6: the edge before done accepted the last operation
            check(hs_flag && !busy, "R6 done follows final handshake", int'(hs_flag), 1);
            // R7
            check(cnt_reset == CW'(31 * NB + 1), "R7 reset count", int'(cnt_reset), 31 * NB + 1);
            check(cnt_imply == CW'(28 * NB), "R7 imply count", int'(cnt_imply), 28 * NB);
            break;
         end
         if (abort) begin
            got_abort = 1'b1;
            break;
         end
      end
      start = 1'b0;
      op_ready = 1'b0;
   endtask

   initial begin
      bit d, ab;
      logic [8:0] res;
      logic [7:0] ra, rb;

      repeat (4) @(negedge clk);
      // R1: state during reset
      check(!busy && !done && !abort && !op_valid, "R1 outputs in reset", int'(op_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !abort && !op_valid, "R1 outputs after reset", int'(busy), 0);
      check(cnt_reset == '0 && cnt_imply == '0, "R1 counters zero", int'(cnt_reset), 0);

      for (int v = 0; v < NV; v++) begin
         // R11: odd vectors run with random ready stalls; R10: vector 3 sees a stray start
         run_add(VEC[v][24:17], VEC[v][16:9], bit'(v % 2), v == 3, d, ab);
         check(d && !ab, "R4 run completes", int'(d), 1);
         for (int i = 0; i < NB; i++) res[i] = mem[2 * NB + i];
         res[NB] = mem[3 * NB];
         check(res == VEC[v][8:0], (v == 3) ? "R10 sum after stray start" : "R4 sum and overflow",
               int'(res), int'(VEC[v][8:0]));
         for (int i = 0; i < NB; i++) begin
            ra[i] = mem[i];
            rb[i] = mem[NB + i];
         end
         check(ra == VEC[v][24:17] && rb == VEC[v][16:9], "R5 operands kept",
               int'({ra, rb}), int'(VEC[v][24:9]));
         // R3: prologue clears the carry-in cell
         check(first_code == 1'b0 && int'(first_tgt) == 3 * NB + 1, "R3 first op clears carry-in",
               int'(first_tgt), 3 * NB + 1);
         check(illegal == 0, "R8 legal operations", illegal, 0);
         @(negedge clk);
         check(!done, "R6 done single cycle", int'(done), 0);
      end

      // R2: an operation presented under a stall is the one then accepted
      begin
         logic [AW-1:0] held;
         @(negedge clk);
         start = 1'b1;
         op_ready = 1'b0;
         @(negedge clk);
         start = 1'b0;
         held = op_tgt;
         repeat (3) @(negedge clk);
         check(op_valid && op_tgt == held && op_code == 1'b0, "R2 held under stall",
               int'(op_tgt), int'(held));
         op_ready = 1'b1;
         @(negedge clk);
         check(first_tgt == held, "R2 accepted op matches held op", int'(first_tgt), int'(held));
         while (busy) @(negedge clk);
         op_ready = 1'b0;
      end

      // R9: reject the operation with index 20
      inject_at = 20;
      run_add(8'd77, 8'd88, 1'b0, 1'b0, d, ab);
      check(ab && !d, "R9 abort pulse", int'(ab), 1);
      check(int'(cnt_reset) + int'(cnt_imply) == 20, "R9 counts exclude rejected op",
            int'(cnt_reset) + int'(cnt_imply), 20);
      op_ready = 1'b1;
      begin
         bit quiet = 1'b1;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (op_valid || busy || done) quiet = 1'b0;
         end
         check(quiet, "R9 no further ops after abort", int'(quiet), 1);
      end
      op_ready = 1'b0;
      inject_at = -1;

      // recovery after abort (R4)
      run_add(8'd255, 8'd255, 1'b1, 1'b0, d, ab);
      for (int i = 0; i < NB; i++) res[i] = mem[2 * NB + i];
      res[NB] = mem[3 * NB];
      check(d && res == 9'd510, "R4 sum after abort recovery", int'(res), 510);

      summary();
      $finish;
   end

endmodule